// File: doc/BRIEF.md
# Transmit Bit Retiming Latch

This block sits in front of a frequency-shift-keyed transmitter. It lets a host controller with no serial port of its own send 1200 bit/s data one bit at a time, paced by a handshake strobe. Two single-bit registers are placed in series between the data pin and the modulator bit. The host loads the first register with a rising edge on the strobe. An internal bit-period tick, made by dividing the system clock, moves that bit into the second register. An active-low ready output tells the host when to supply the next bit.

At every tick the block reads the strobe level to choose its mode. A high strobe selects bypass, where the synchronized data pin drives the modulator directly. A low strobe selects retimed operation, where the second register drives the modulator and ready is asserted. The host releases ready by raising the strobe. When the fast transmit mode is off, as for the slow back channel, the data pin always passes straight through and ready stays inactive.

The controller has three states:
- `ST_BYPASS`: the pin passes through.
- `ST_REQ`: retimed, with ready asserted.
- `ST_HELD`: retimed, with ready released.

Its transitions are:
- BYPASS→REQ on a tick with the strobe low; BYPASS stays put on a tick with the strobe high.
- REQ→HELD when the strobe is high between ticks.
- REQ→REQ on a tick with the strobe still low.
- REQ→BYPASS or HELD→BYPASS on a tick with the strobe high.
- HELD→REQ on a tick with the strobe low.
- Any state→BYPASS whenever fast mode is off.

Top module: `tx_bit_retimer`

## Requirements
- R1: During and right after reset both bit registers hold 1, `mod_bit_out` is 1 and `ready_n` is 1.
- R2: The internal tick is a one-cycle pulse that occurs every `TICK_DIV` clock cycles, the first one `TICK_DIV` cycles after reset is released.
- R3: The data pin, after `SYNC_STAGES` flops, is loaded into the first register only on a detected rising edge of the synchronized strobe; later changes of the data pin with no new rising edge are not transmitted.
- R4: On each tick the second register loads the first register, and it holds its value between ticks; a host that misses a tick gets the same bit sent again.
- R5: If the synchronized strobe is high at a tick, the block enters bypass and `mod_bit_out` equals the data pin delayed by `SYNC_STAGES` cycles.
- R6: If the synchronized strobe is low at a tick while `fast_tx_en` is 1, `mod_bit_out` is driven by the second register and `ready_n` goes to 0 in the cycle after the tick.
- R7: A high synchronized strobe returns `ready_n` to 1 by the next cycle, that is `SYNC_STAGES`+1 cycles after the strobe pin rises.
- R8: When `fast_tx_en` is 0, `mod_bit_out` equals the data pin delayed by `SYNC_STAGES` cycles, `ready_n` is 1 at once, and the controller is in bypass from the next cycle on.
- R9: In retimed operation, successive falls of `ready_n` and updates of `mod_bit_out` are exactly `TICK_DIV` cycles apart. The default of 2983 gives 1200 bit/s from a 3.579545 MHz clock, inside the 1194 to 1206 baud window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_bit_in | input | 1 | Transmit data from the host |
| hs_clk_in | input | 1 | Handshake strobe from the host |
| fast_tx_en | input | 1 | 1 = 1200 bit/s transmit mode, retiming possible; 0 = direct pass-through |
| mod_bit_out | output | 1 | Bit presented to the modulator |
| ready_n | output | 1 | Active-low request for the next bit |

## Verification
The assertions take `fast_tx_en` to be a level that the host changes rarely, and take the strobe and data pins to be asynchronous but seen only through the synchronizer. They also assume that a host in retimed mode raises the strobe once per request, well inside one tick period. The stimulus respects this in its directed handshake phases: it waits for ready, presents the bit, then pulses the strobe for a few cycles. A later sweep toggles every input at random, including the mode. Throughout that sweep the bench compares the outputs against a cycle model built from the requirements. This covers the orderings where the strobe, a tick and a mode change land in the same cycle.

// File: rtl/txrt_pkg.sv
package txrt_pkg;

    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_REQ    = 2'd1,
        ST_HELD   = 2'd2
    } rt_state_e;

    localparam int unsigned TICK_DIV_DEFAULT = 2983;
    localparam int unsigned SYNC_DEFAULT     = 2;
    localparam logic        MARK_LEVEL       = 1'b1;

endpackage

// File: rtl/txrt_sync.sv
module txrt_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                chain[i] <= RST_VAL;
            end
        end else begin
            chain[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/txrt_tick.sv
module txrt_tick #(
    parameter int unsigned DIV = 2983
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);

    // R2: a tick never repeats in the following cycle
    a_r2_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/txrt_capture.sv
module txrt_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_s,
    input  logic txd_s,
    output logic stage1
);

    import txrt_pkg::*;

    logic hs_prev;
    logic hs_rise;

    assign hs_rise = hs_s & ~hs_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_prev <= 1'b1;
            stage1  <= MARK_LEVEL;
        end else begin
            hs_prev <= hs_s;
            if (hs_rise) begin
                stage1 <= txd_s;
            end
        end
    end

    // R3: the first register only moves on a strobe rising edge
    a_r3_hold_without_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_s && !hs_prev) |=> $stable(stage1));

endmodule

// File: rtl/txrt_ctrl.sv
module txrt_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hs_s,
    input  logic txd_s,
    input  logic stage1,
    input  logic fast_en,
    output logic mod_bit,
    output logic ready_n
);

    import txrt_pkg::*;

    rt_state_e state;
    rt_state_e state_nxt;
    logic      stage2;

    // second register: loaded on every tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage2 <= MARK_LEVEL;
        end else if (tick) begin
            stage2 <= stage1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BYPASS;
        end else begin
            state <= state_nxt;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_BYPASS: begin
                if (tick && !hs_s) state_nxt = ST_REQ;
            end
            ST_REQ: begin
                if (tick)      state_nxt = hs_s ? ST_BYPASS : ST_REQ;
                else if (hs_s) state_nxt = ST_HELD;
            end
            ST_HELD: begin
                if (tick)      state_nxt = hs_s ? ST_BYPASS : ST_REQ;
            end
            default: state_nxt = ST_BYPASS;
        endcase
        if (!fast_en) state_nxt = ST_BYPASS;
    end

    // outputs
    always_comb begin
        mod_bit = txd_s;
        ready_n = 1'b1;
        if (fast_en) begin
            unique case (state)
                ST_BYPASS: mod_bit = txd_s;
                ST_REQ: begin
                    mod_bit = stage2;
                    ready_n = 1'b0;
                end
                ST_HELD:   mod_bit = stage2;
                default:   mod_bit = txd_s;
            endcase
        end
    end

    // R4: second register is stable between ticks
    a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(stage2));

    // R6: low strobe at a tick in fast mode raises the request
    a_r6_request_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hs_s && fast_en) |=> (ready_n == !fast_en));

    // R7: a high strobe releases ready by the next cycle
    a_r7_release_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        hs_s |=> ready_n);

    // R8: slow mode forces bypass
    a_r8_slow_forces_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_en |=> (state == ST_BYPASS));

endmodule

// File: rtl/tx_bit_retimer.sv
module tx_bit_retimer #(
    parameter int unsigned TICK_DIV    = txrt_pkg::TICK_DIV_DEFAULT,
    parameter int unsigned SYNC_STAGES = txrt_pkg::SYNC_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_bit_in,
    input  logic hs_clk_in,
    input  logic fast_tx_en,
    output logic mod_bit_out,
    output logic ready_n
);

    localparam int unsigned SYNC_W = 2;

    logic [SYNC_W-1:0] pins_s;
    logic              hs_s;
    logic              txd_s;
    logic              tick;
    logic              stage1;

    txrt_sync #(
        .W      (SYNC_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL('1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({hs_clk_in, tx_bit_in}),
        .q    (pins_s)
    );

    assign hs_s  = pins_s[1];
    assign txd_s = pins_s[0];

    txrt_tick #(
        .DIV(TICK_DIV)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    txrt_capture u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .hs_s  (hs_s),
        .txd_s (txd_s),
        .stage1(stage1)
    );

    txrt_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .hs_s   (hs_s),
        .txd_s  (txd_s),
        .stage1 (stage1),
        .fast_en(fast_tx_en),
        .mod_bit(mod_bit_out),
        .ready_n(ready_n)
    );

endmodule

// File: tb/test_tx_bit_retimer.sv
module test_tx_bit_retimer;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 12;
    localparam int SYNC       = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic d_in = 1'b1;
    logic h_in = 1'b1;
    logic en = 1'b0;
    logic mod_out;
    logic rdy_n;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;
    logic pd1 = 1'b1;
    logic pd2 = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_bit_retimer #(.TICK_DIV(DIV), .SYNC_STAGES(SYNC)) i_tx_bit_retimer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_bit_in  (d_in),
        .hs_clk_in  (h_in),
        .fast_tx_en (en),
        .mod_bit_out(mod_out),
        .ready_n    (rdy_n)
    );

    // cycle model built from the requirements
    logic [SYNC-1:0] m_dch, m_hch;
    logic m_hprev, m_s1, m_s2;
    int   m_cnt;
    int   m_st; // 0 bypass, 1 request, 2 held
    wire  m_ds   = m_dch[SYNC-1];
    wire  m_hs   = m_hch[SYNC-1];
    wire  m_tick = (m_cnt == DIV - 1);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dch <= '1; m_hch <= '1; m_hprev <= 1'b1;
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_cnt <= 0; m_st <= 0;
        end else begin
            m_dch <= {m_dch[SYNC-2:0], d_in};
            m_hch <= {m_hch[SYNC-2:0], h_in};
            m_hprev <= m_hs;
            if (m_hs && !m_hprev) m_s1 <= m_ds;
            if (m_tick) m_s2 <= m_s1;
            m_cnt <= m_tick ? 0 : m_cnt + 1;
            if (!en)                 m_st <= 0;
            else if (m_tick)         m_st <= m_hs ? 0 : 1;
            else if (m_st == 1 && m_hs) m_st <= 2;
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            logic e_mod, e_rdy;
            e_mod = (en && m_st != 0) ? m_s2 : m_ds;
            e_rdy = !(en && m_st == 1);
            chk(mod_out === e_mod, "R5/R6 model mod_bit_out", mod_out, e_mod);
            chk(rdy_n === e_rdy, "R6/R7 model ready_n", rdy_n, e_rdy);
        end
    end

    task automatic summary_and_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            summary_and_end();
        end
    end

    task automatic nxt();
        @(negedge clk);
        pd2 = pd1;
        pd1 = d_in;
        #1;
    endtask

    task automatic wait_ready(output bit got);
        got = 1'b0;
        for (int i = 0; i < 4*DIV; i++) begin
            nxt();
            if (rdy_n === 1'b0) begin
                got = 1'b1;
                break;
            end
        end
        if (!got) chk(1'b0, "R6 ready never fell", rdy_n, 1'b0);
    endtask

    initial begin
        bit got;
        int last_fall;
        logic prev_bit;
        logic [7:0] pattern;
        logic [15:0] lfsr;
        pattern = 8'b1011_0010;

        // R1: reset state
        repeat (3) nxt();
        chk(mod_out === 1'b1, "R1 mod_bit_out in reset", mod_out, 1'b1);
        chk(rdy_n === 1'b1, "R1 ready_n in reset", rdy_n, 1'b1);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        nxt();
        chk(mod_out === 1'b1, "R1 mod_bit_out after reset", mod_out, 1'b1);

        // R8: slow mode, strobe low, data passes through
        en = 1'b0; h_in = 1'b0;
        for (int i = 0; i < 3*DIV; i++) begin
            nxt();
            if (i > 1) begin
                chk(mod_out === pd2, "R8 slow mode pass-through", mod_out, pd2);
                chk(rdy_n === 1'b1, "R8 slow mode ready idle", rdy_n, 1'b1);
            end
            d_in = ((i / 5) % 2 == 0);
        end

        // R5: fast mode with strobe held high stays bypass
        en = 1'b1; h_in = 1'b1;
        for (int i = 0; i < 3*DIV; i++) begin
            nxt();
            if (i > DIV) begin
                chk(mod_out === pd2, "R5 bypass follows data", mod_out, pd2);
                chk(rdy_n === 1'b1, "R5 bypass ready idle", rdy_n, 1'b1);
            end
            d_in = ((i / 3) % 2 == 1);
        end

        // R2/R3/R4/R6/R7/R9: handshake transfer of a pattern
        h_in = 1'b0; d_in = 1'b1;
        last_fall = 0;
        prev_bit = 1'b1;
        for (int k = 0; k <= 8; k++) begin
            wait_ready(got);
            if (!got) break;
            chk(rdy_n === 1'b0, "R6 ready asserted", rdy_n, 1'b0);
            if (k > 0) begin
                chk((cyc - last_fall) == DIV, "R9 request spacing", 1'b0, 1'b1);
                chk((cyc - last_fall) % DIV == 0, "R2 tick period", 1'b0, 1'b1);
                chk(mod_out === prev_bit, "R4 retimed bit sent", mod_out, prev_bit);
            end
            last_fall = cyc;
            if (k == 8) break;
            d_in = pattern[k];
            prev_bit = pattern[k];
            h_in = 1'b1;
            repeat (SYNC + 1) nxt();
            chk(rdy_n === 1'b1, "R7 ready released", rdy_n, 1'b1);
            nxt();
            h_in = 1'b0;
            d_in = ~pattern[k]; // R3: not captured without a new edge
        end

        // R4: host misses a tick, same bit repeats and request stays
        repeat (DIV) nxt();
        chk(rdy_n === 1'b0, "R4 request persists", rdy_n, 1'b0);
        chk(mod_out === prev_bit, "R4 bit repeated", mod_out, prev_bit);
        chk(mod_out === prev_bit, "R3 late data ignored", mod_out, prev_bit);

        // R7 then R5: strobe high, release then bypass at next tick
        h_in = 1'b1;
        repeat (SYNC + 1) nxt();
        chk(rdy_n === 1'b1, "R7 release after long request", rdy_n, 1'b1);
        repeat (DIV + 2) nxt();
        chk(mod_out === pd2, "R5 back to bypass", mod_out, pd2);

        // R8: leaving fast mode while a request is pending
        h_in = 1'b0;
        wait_ready(got);
        en = 1'b0;
        d_in = ~d_in;
        nxt();
        chk(rdy_n === 1'b1, "R8 ready drops with mode", rdy_n, 1'b1);
        chk(mod_out === pd2, "R8 direct path with mode off", mod_out, pd2);
        en = 1'b1;
        nxt();
        chk(rdy_n === 1'b1, "R8 bypass after mode toggle", rdy_n, 1'b1);

        // sweep: pseudo-random inputs against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            nxt();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            d_in = lfsr[0];
            if (lfsr[3:1] == 3'b000) h_in = ~h_in;
            if (lfsr[9:4] == 6'd0) en = ~en;
        end

        nxt();
        cmp_on = 1'b0;
        summary_and_end();
    end

endmodule